// File: doc/BRIEF.md
# Binary-Tree Piecewise-Affine Evaluator

This block computes a piecewise-affine function of up to four signed 12-bit fixed-point inputs. The input space is split into regions by hyperplanes, and the split is held as a binary search tree in an external tree memory. Each tree entry is a 12-bit pointer into an external coefficient memory. Each coefficient word packs four hyperplane weights and one constant. One multiply-accumulate datapath serves two purposes. At an internal node, the sign of its result picks the child to visit next. At a leaf, its value is the function's output.

A start pulse captures the inputs, the number of active inputs and the tree depth. The block then walks from the root to a leaf, issuing one tree read and one coefficient read per level. It presents a 26-bit signed result together with a one-cycle done strobe. Both memories sit outside the block and answer a read one clock cycle after the address is presented.

Top module: `pwa_tree_eval`

## Requirements
- R1: After reset, `busy`, `done`, `tmem_rd` and `pmem_rd` are low and `result` is zero.
- R2: Input lane i occupies `x_in[12*i+11:12*i]`. Lanes whose index is `n_active` or above are replaced by zero when `start` is accepted.
- R3: A coefficient word holds the weights for lanes 0..3 in bits [11:0], [23:12], [35:24] and [47:36], and the constant in [59:48]. Each 12x12 signed product is sign-extended to 26 bits, and the sum of the four products and the constant is exact in 26 bits.
- R4: Nodes use heap numbering with the root at tree address 1. After node i, the next tree address is 2i when the sum is zero or negative, and 2i+1 when it is positive.
- R5: A sum of exactly zero selects the even (left) child.
- R6: With depth d, the block makes d decisions and then reports the sum of the node reached at level d. A `depth_cfg` above 13 behaves as 13. No tree address reaches 2^(d+1) or above.
- R7: `done` rises 2d+3 clock edges after the edge that samples `start`. It stays high for exactly one cycle, and `busy` is low while it is high.
- R8: A `start` seen while `busy` is high is ignored. The running evaluation keeps its captured inputs and its result.
- R9: Every coefficient read is issued in the cycle after a tree read, with `pmem_addr` equal to the tree word returned by that read.
- R10: `result` holds its value between done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an evaluation (taken only when idle) |
| n_active | input | 3 | Number of active input lanes, 0 to 4 |
| depth_cfg | input | 4 | Number of tree decisions before the leaf |
| x_in | input | 48 | Four packed signed 12-bit inputs |
| tmem_rd | output | 1 | Tree memory read enable |
| tmem_addr | output | 14 | Tree memory address (heap node index) |
| tmem_data | input | 12 | Tree memory word, valid one cycle after the read |
| pmem_rd | output | 1 | Coefficient memory read enable |
| pmem_addr | output | 12 | Coefficient memory address |
| pmem_data | input | 60 | Coefficient word, valid one cycle after the read |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle strobe: `result` is new |
| result | output | 26 | Signed affine value of the leaf reached |

## Verification
The assertions assume that both memories return their word exactly one cycle after a read and hold it until the next read. They also assume that `depth_cfg` and `n_active` are sampled only together with an accepted `start`. The bench builds both memories as registered models whose contents are computed from the address and a per-scenario seed, so they always follow that one-cycle timing. It changes `depth_cfg`, `n_active` and `x_in` only at job boundaries, except in the deliberate busy-time start tests.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  localparam int XW        = 12;
  localparam int NX        = 4;
  localparam int NC        = NX + 1;
  localparam int PW        = NC * XW;
  localparam int XVW       = NX * XW;
  localparam int RW        = 26;
  localparam int MAX_DEPTH = 13;
  localparam int TAW       = MAX_DEPTH + 1;
  localparam int PAW       = 12;
  localparam int DW        = $clog2(MAX_DEPTH + 1);
  localparam int NW        = $clog2(NX + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TREE,
    ST_PARM,
    ST_EVAL
  } walk_st_t;

  // slice number idx of a packed vector of XW-bit fields
  function automatic logic signed [XW-1:0] field_at(input logic [PW-1:0] vec, input int idx);
    return $signed(vec[idx*XW +: XW]);
  endfunction

  // signed product widened to the result width
  function automatic logic signed [RW-1:0] widen_prod(input logic signed [XW-1:0] a,
                                                      input logic signed [XW-1:0] b);
    logic signed [2*XW-1:0] p;
    p = a * b;
    return {{(RW-2*XW){p[2*XW-1]}}, p};
  endfunction

  function automatic logic signed [RW-1:0] widen_const(input logic signed [XW-1:0] k);
    return {{(RW-XW){k[XW-1]}}, k};
  endfunction

  function automatic logic [DW-1:0] clamp_depth(input logic [DW-1:0] d);
    return (d > DW'(MAX_DEPTH)) ? DW'(MAX_DEPTH) : d;
  endfunction
endpackage

// File: rtl/pwa_input_latch.sv
module pwa_input_latch
  import pwa_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [NW-1:0]  n_sel,
  input  logic [XVW-1:0] x_raw,
  output logic [XVW-1:0] x_q,
  output logic [NW-1:0]  n_q
);
  logic [XW-1:0] lane_q [NX];

  for (genvar g = 0; g < NX; g++) begin : g_lane
    logic lane_on;
    assign lane_on = (NW'(g) < n_sel);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lane_q[g] <= '0;
      end else if (load) begin
        lane_q[g] <= lane_on ? x_raw[g*XW +: XW] : '0;
      end
    end

    assign x_q[g*XW +: XW] = lane_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
    end else if (load) begin
      n_q <= n_sel;
    end
  end
endmodule

// File: rtl/pwa_mac_unit.sv
module pwa_mac_unit
  import pwa_pkg::*;
(
  input  logic [XVW-1:0]        x_vec,
  input  logic [PW-1:0]         pword,
  output logic signed [RW-1:0]  sum,
  output logic                  positive
);
  logic signed [RW-1:0] prod [NX];
  logic [PW-1:0]        x_wide;

  assign x_wide = {{XW{1'b0}}, x_vec};

  for (genvar g = 0; g < NX; g++) begin : g_mul
    assign prod[g] = widen_prod(field_at(x_wide, g), field_at(pword, g));
  end

  always_comb begin
    sum = widen_const(field_at(pword, NX));
    for (int i = 0; i < NX; i++) begin
      sum = sum + prod[i];
    end
  end

  assign positive = !sum[RW-1] && (sum != '0);
endmodule

// File: rtl/pwa_walker.sv
module pwa_walker
  import pwa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DW-1:0]        depth_in,
  input  logic [PAW-1:0]       tree_word,
  input  logic signed [RW-1:0] mac_sum,
  input  logic                 mac_pos,
  output logic                 load,
  output logic                 tree_rd,
  output logic [TAW-1:0]       tree_addr,
  output logic                 parm_rd,
  output logic [PAW-1:0]       parm_addr,
  output logic                 leaf_eval,
  output logic [DW-1:0]        depth_q,
  output logic                 busy,
  output logic                 done,
  output logic [RW-1:0]        result
);
  walk_st_t       state_q;
  logic [TAW-1:0] node_q;
  logic [DW-1:0]  level_q;
  logic [TAW-1:0] child;
  logic           accept;

  assign accept    = start && (state_q == ST_IDLE);
  assign load      = accept;
  assign busy      = (state_q != ST_IDLE);
  assign leaf_eval = (state_q == ST_EVAL) && (level_q == depth_q);
  assign child     = {node_q[TAW-2:0], mac_pos};

  assign tree_rd   = (state_q == ST_TREE) || ((state_q == ST_EVAL) && !leaf_eval);
  assign tree_addr = (state_q == ST_TREE) ? node_q : child;
  assign parm_rd   = (state_q == ST_PARM);
  assign parm_addr = tree_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      node_q  <= TAW'(1);
      level_q <= '0;
      depth_q <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_TREE;
            node_q  <= TAW'(1);
            level_q <= '0;
            depth_q <= clamp_depth(depth_in);
          end
        end
        ST_TREE: state_q <= ST_PARM;
        ST_PARM: state_q <= ST_EVAL;
        ST_EVAL: begin
          if (leaf_eval) begin
            state_q <= ST_IDLE;
            result  <= mac_sum;
            done    <= 1'b1;
          end else begin
            state_q <= ST_PARM;
            node_q  <= child;
            level_q <= level_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwa_tree_eval.sv
module pwa_tree_eval
  import pwa_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [NW-1:0]  n_active,
  input  logic [DW-1:0]  depth_cfg,
  input  logic [XVW-1:0] x_in,
  output logic           tmem_rd,
  output logic [TAW-1:0] tmem_addr,
  input  logic [PAW-1:0] tmem_data,
  output logic           pmem_rd,
  output logic [PAW-1:0] pmem_addr,
  input  logic [PW-1:0]  pmem_data,
  output logic           busy,
  output logic           done,
  output logic [RW-1:0]  result
);
  // named internal events, observed by the bound checker
  logic                 load;
  logic [XVW-1:0]       x_lat;
  logic [NW-1:0]        n_lat;
  logic                 leaf_eval;
  logic [DW-1:0]        depth_lvl;
  logic signed [RW-1:0] mac_sum;
  logic                 mac_pos;

  pwa_input_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .n_sel (n_active),
    .x_raw (x_in),
    .x_q   (x_lat),
    .n_q   (n_lat)
  );

  pwa_mac_unit u_mac (
    .x_vec    (x_lat),
    .pword    (pmem_data),
    .sum      (mac_sum),
    .positive (mac_pos)
  );

  pwa_walker u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .depth_in  (depth_cfg),
    .tree_word (tmem_data),
    .mac_sum   (mac_sum),
    .mac_pos   (mac_pos),
    .load      (load),
    .tree_rd   (tmem_rd),
    .tree_addr (tmem_addr),
    .parm_rd   (pmem_rd),
    .parm_addr (pmem_addr),
    .leaf_eval (leaf_eval),
    .depth_q   (depth_lvl),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );
endmodule

// File: rtl/pwa_tree_eval_chk.sv
module pwa_tree_eval_chk
  import pwa_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           tmem_rd,
  input logic [TAW-1:0] tmem_addr,
  input logic           pmem_rd,
  input logic           leaf_eval,
  input logic [DW-1:0]  depth_lvl,
  input logic [XVW-1:0] x_lat,
  input logic [NW-1:0]  n_lat
);
  assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_after_leaf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(leaf_eval));

  assert_addr_in_tree_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tmem_rd |-> ((tmem_addr >> (depth_lvl + 1'b1)) == '0));

  assert_child_heap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmem_rd && $past(tmem_rd, 2)) |-> ((tmem_addr >> 1) == $past(tmem_addr, 2)));

  assert_param_after_tree_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_rd |-> $past(tmem_rd));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(x_lat));

  assert_unused_lane_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (n_lat < NW'(NX))) |-> (x_lat[(NX-1)*XW +: XW] == '0));
endmodule

bind pwa_tree_eval pwa_tree_eval_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .tmem_rd   (tmem_rd),
  .tmem_addr (tmem_addr),
  .pmem_rd   (pmem_rd),
  .leaf_eval (leaf_eval),
  .depth_lvl (depth_lvl),
  .x_lat     (x_lat),
  .n_lat     (n_lat)
);

// File: tb/pwa_tree_eval_bench.sv
module pwa_tree_eval_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  n_active = 3'd4;
  logic [3:0]  depth_cfg = 4'd1;
  logic [47:0] x_in = '0;
  logic        tmem_rd;
  logic [13:0] tmem_addr;
  logic [11:0] tmem_data = '0;
  logic        pmem_rd;
  logic [11:0] pmem_addr;
  logic [59:0] pmem_data = '0;
  logic        busy, done;
  logic [25:0] result;

  int errors = 0;
  int checks = 0;
  int unsigned mem_seed = 32'h1234_5678;
  int mem_mode = 0;     // 0 random, 1 extreme, 2 tie
  int tie_depth = 3;
  bit finished = 0;

  always #10 clk = ~clk;

  pwa_tree_eval u_pwa_tree_eval (
    .clk(clk), .rst_n(rst_n), .start(start), .n_active(n_active),
    .depth_cfg(depth_cfg), .x_in(x_in), .tmem_rd(tmem_rd), .tmem_addr(tmem_addr),
    .tmem_data(tmem_data), .pmem_rd(pmem_rd), .pmem_addr(pmem_addr),
    .pmem_data(pmem_data), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [31:0] mix(input logic [31:0] v);
    v = v ^ (v >> 16);
    v = v * 32'h045d_9f3b;
    v = v ^ (v >> 13);
    v = v * 32'h2c1b_3c6d;
    return v ^ (v >> 16);
  endfunction

  function automatic logic [11:0] tree_word(input int node);
    if (mem_mode == 2) return node[11:0];
    return mix(node ^ mem_seed)[11:0];
  endfunction

  function automatic logic [59:0] coef_word(input int a);
    logic [31:0] lo, hi;
    if (mem_mode == 1) return {12'h7FF, 12'h800, 12'h800, 12'h800, 12'h800};
    if (mem_mode == 2) return {((a >= (1 << tie_depth)) ? a[11:0] : 12'h000), 48'h0};
    lo = mix(a ^ mem_seed ^ 32'h00ab_cdef);
    hi = mix(a + mem_seed + 32'h7777);
    return {hi[27:0], lo};
  endfunction

  always_ff @(posedge clk) begin
    if (tmem_rd) tmem_data <= tree_word(int'(tmem_addr));
    if (pmem_rd) pmem_data <= coef_word(int'(pmem_addr));
  end

  // reference walk written from the requirements (R2..R6)
  function automatic int ref_eval(input logic [47:0] xv, input int n, input int d);
    int node = 1;
    int dd = (d > 13) ? 13 : d;
    int s = 0;
    for (int lvl = 0; lvl <= dd; lvl++) begin
      logic [59:0] w = coef_word(int'(tree_word(node)));
      s = int'($signed(w[59:48]));
      for (int i = 0; i < 4; i++) begin
        int xi = (i < n) ? int'($signed(xv[i*12 +: 12])) : 0;
        s += xi * int'($signed(w[i*12 +: 12]));
      end
      if (lvl < dd) node = (s > 0) ? 2 * node + 1 : 2 * node;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one job: start on a negedge; optional busy-time start at cycle 3 with other inputs
  task automatic run_job(input logic [47:0] xv, input int n, input int d, input bit poke);
    int cnt = 0;
    int exp = ref_eval(xv, n, d);
    int dd = (d > 13) ? 13 : d;
    logic [25:0] held;
    @(negedge clk);
    x_in = xv; n_active = 3'(n); depth_cfg = 4'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    while (!done && cnt < 100) begin
      @(negedge clk);
      cnt++;
      if (pmem_rd) check(pmem_addr == tmem_data, "R9 coef addr from tree word",
                         int'(pmem_addr), int'(tmem_data));
      if (poke && cnt == 3) begin
        x_in = ~xv; start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(cnt == 2 * dd + 3, "R7 latency", cnt, 2 * dd + 3);
    check($signed(result) == 26'(exp), poke ? "R8 result after ignored start" : "R3 R4 leaf value",
          int'($signed(result)), exp);
    check(!busy, "R7 not busy at done", int'(busy), 0);
    held = result;
    @(negedge clk);
    check(!done, "R7 done single cycle", int'(done), 0);
    @(negedge clk);
    check(result == held, "R10 result held", int'($signed(result)), int'($signed(held)));
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !done && !tmem_rd && !pmem_rd, "R1 idle after reset",
          int'({busy, done, tmem_rd, pmem_rd}), 0);
    check(result == '0, "R1 result zero", int'(result), 0);
    rst_n = 1'b1;

    // random traffic, all lane counts and depths
    for (int j = 0; j < 60; j++) begin
      mem_seed = $urandom();
      run_job({$urandom(), $urandom()}, j % 5, 1 + ($urandom() % 13), 1'b0);
    end

    // R2: upper lanes carry garbage that must not matter
    run_job(48'hFFF_7FF_800_123, 1, 6, 1'b0);
    run_job(48'h800_800_7FF_001, 2, 9, 1'b0);

    // R8: start pulsed while busy
    run_job({$urandom(), $urandom()}, 4, 5, 1'b1);
    run_job({$urandom(), $urandom()}, 3, 12, 1'b1);

    // R6: depth above the maximum behaves as 13
    run_job({$urandom(), $urandom()}, 4, 15, 1'b0);
    run_job({$urandom(), $urandom()}, 4, 13, 1'b0);

    // R3: extreme operands, largest magnitudes
    mem_mode = 1;
    run_job({4{12'h800}}, 4, 4, 1'b0);
    run_job({4{12'h7FF}}, 4, 4, 1'b0);
    check($signed(result) == -26'sd16766977, "R3 extreme negative sum",
          int'($signed(result)), -16766977);

    // R5: every decision is a zero tie, so the leftmost leaf 2^d is reached
    mem_mode = 2;
    for (int d = 1; d <= 10; d += 3) begin
      tie_depth = d;
      run_job({$urandom(), $urandom()}, 4, d, 1'b0);
      check($signed(result) == 26'(1 << d), "R5 tie goes left",
            int'($signed(result)), 1 << d);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule